// File: doc/BRIEF.md
# SHAKE-128 Uniform Rejection Sampler

This block converts squeezed extendable-output rate blocks into one polynomial of 256 coefficients, each uniform in the range 0 to 3328. An external permutation engine presents a 1344-bit rate block on a valid/ready input. The sampler reads that block three bytes at a time. Each three-byte group yields two 12-bit candidates. A candidate below 3329 is forwarded on a valid/ready coefficient stream. A candidate at or above 3329 is dropped.

A start pulse clears the sampler, which then waits for the first block. The block does not ask for a new permutation after each group. It uses every one of the 56 groups in the block first, and only then pulses a squeeze request and waits for the next block. Once the 256th coefficient has been taken downstream, the sampler raises a done flag and ignores any groups left in the final block. Permutation, seed absorption and coefficient storage are handled outside this block.

Top module: `shake_rej_sampler`

## Requirements
- R1: After reset all outputs are low: `coef_valid_o`, `blk_ready_o`, `sqz_req_o` and `done_o`.
- R2: Group g of a rate block occupies bits 24g+23 down to 24g. Byte b0 is bits 24g+7:24g, b1 is the next byte up, and b2 is the top byte. Group 0 sits at the least significant end.
- R3: The first candidate is b0 + 256*(b1 mod 16). The second is (b1 >> 4) + 16*b2. The first is always presented before the second.
- R4: A candidate is emitted if and only if it is below 3329. A rejected candidate produces no output and costs one cycle.
- R5: Groups are used in the order 0 to 55. `blk_ready_o` rises, and `sqz_req_o` pulses for one cycle, only after the second candidate of group 55 has been dealt with. A new block is loaded on `blk_valid_i && blk_ready_o`.
- R6: Exactly 256 coefficients are emitted per polynomial. If the 256th is a first candidate, the second candidate of that group is discarded.
- R7: `done_o` rises in the cycle after the 256th handshake and stays high until the next start. While done, no coefficient is offered and no block is requested, so the groups left in the final block are ignored.
- R8: `start_i` clears the coefficient count and the group pointer from any state. In the next cycle `done_o` is low and `blk_ready_o` is high.
- R9: While `coef_valid_o` is high and `coef_ready_i` is low, `coef_o` and `coef_valid_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new polynomial |
| blk_data_i | input | 1344 | Squeezed rate block |
| blk_valid_i | input | 1 | Rate block present |
| blk_ready_o | output | 1 | Sampler waits for a rate block |
| sqz_req_o | output | 1 | One-cycle pulse when the current block is exhausted |
| coef_o | output | 12 | Accepted coefficient |
| coef_valid_o | output | 1 | Coefficient present |
| coef_ready_i | input | 1 | Downstream takes the coefficient |
| done_o | output | 1 | 256 coefficients delivered |

## Verification
Four block patterns are used, and each exposes a different kind of fault.

- **Arithmetic bytes, reference comparison.** A block built from arithmetic bytes gives a mixed stream of accepted and rejected candidates. The output sequence is compared with an independent reference model. A mismatch points to a swapped nibble, the wrong byte order, or the wrong order of the two candidates.
- **Exact threshold.** A pattern that sets every first candidate to exactly 3328 and every second to exactly 3329 checks the threshold from both sides. The polynomial ends part-way through the fifth block, so this pattern also checks that the leftover groups are ignored.
- **256th is a first candidate.** A pattern whose 256th coefficient is a first candidate, followed by an acceptable second one, shows whether the sampler stops on time.
- **All zeros.** An all-zero pattern checks the lowest value.

Random back-pressure checks that the coefficient holds while stalled. A restart in the middle of a run checks that the start pulse clears the count and the pointer.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } rs_state_e;

  localparam int unsigned GRP_BITS = 24;
  localparam int unsigned CAND_W   = 12;

  // First candidate: low byte plus low nibble of the middle byte.
  function automatic logic [CAND_W-1:0] cand_first(input logic [GRP_BITS-1:0] grp);
    return {grp[11:8], grp[7:0]};
  endfunction

  // Second candidate: high nibble of the middle byte plus top byte.
  function automatic logic [CAND_W-1:0] cand_second(input logic [GRP_BITS-1:0] grp);
    return {grp[23:16], grp[15:12]};
  endfunction

  function automatic logic cand_below(input logic [CAND_W-1:0] cand,
                                      input logic [CAND_W-1:0] bound);
    return cand < bound;
  endfunction

endpackage

// File: rtl/rs_block_reg.sv
module rs_block_reg #(
  parameter int unsigned RATE_BITS = 1344,
  parameter int unsigned GRP_BITS  = 24,
  parameter int unsigned NUM_GRPS  = RATE_BITS / GRP_BITS,
  parameter int unsigned PTR_W     = $clog2(NUM_GRPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [RATE_BITS-1:0] data_i,
  input  logic [PTR_W-1:0]     ptr_i,
  output logic [GRP_BITS-1:0]  grp_o
);

  logic [RATE_BITS-1:0] blk_q;
  logic [GRP_BITS-1:0]  grp_arr [NUM_GRPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_q <= '0;
    else if (load_i) blk_q <= data_i;
  end

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    assign grp_arr[g] = blk_q[g*GRP_BITS +: GRP_BITS];
  end

  always_comb begin
    grp_o = '0;
    for (int unsigned g = 0; g < NUM_GRPS; g++) begin
      if (ptr_i == PTR_W'(g)) grp_o = grp_arr[g];
    end
  end

endmodule

// File: rtl/rs_cand_split.sv
module rs_cand_split
  import rs_pkg::*;
#(
  parameter int unsigned MODULUS = 3329
) (
  input  logic [GRP_BITS-1:0] grp_i,
  input  logic                second_i,
  output logic [CAND_W-1:0]   cand_o,
  output logic                ok_o
);

  localparam logic [CAND_W-1:0] BOUND = CAND_W'(MODULUS);

  always_comb begin
    cand_o = second_i ? cand_second(grp_i) : cand_first(grp_i);
    ok_o   = cand_below(cand_o, BOUND);
  end

endmodule

// File: rtl/shake_rej_sampler.sv
module shake_rej_sampler
  import rs_pkg::*;
#(
  parameter int unsigned RATE_BITS  = 1344,
  parameter int unsigned NUM_COEFFS = 256,
  parameter int unsigned MODULUS    = 3329
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [RATE_BITS-1:0] blk_data_i,
  input  logic                 blk_valid_i,
  output logic                 blk_ready_o,
  output logic                 sqz_req_o,
  output logic [CAND_W-1:0]    coef_o,
  output logic                 coef_valid_o,
  input  logic                 coef_ready_i,
  output logic                 done_o
);

  localparam int unsigned NUM_GRPS = RATE_BITS / GRP_BITS;
  localparam int unsigned PTR_W    = $clog2(NUM_GRPS);
  localparam int unsigned CNT_W    = $clog2(NUM_COEFFS + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_GRPS - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_COEFFS - 1);

  rs_state_e          state_q;
  logic [PTR_W-1:0]   ptr_q;
  logic               half_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sqz_q;

  logic [GRP_BITS-1:0] grp;
  logic [CAND_W-1:0]   cand;
  logic                cand_ok;

  // Named internal events, also used by the checker.
  logic blk_load;
  logic cand_step;
  logic coef_take;
  logic last_take;
  logic blk_end;

  assign blk_load  = (state_q == ST_WAIT) && blk_valid_i && !start_i;
  assign cand_step = (state_q == ST_RUN) && (!cand_ok || coef_ready_i);
  assign coef_take = coef_valid_o && coef_ready_i;
  assign last_take = coef_take && (cnt_q == CNT_LAST);
  assign blk_end   = half_q && (ptr_q == PTR_LAST);

  rs_block_reg #(
    .RATE_BITS (RATE_BITS),
    .GRP_BITS  (GRP_BITS),
    .NUM_GRPS  (NUM_GRPS),
    .PTR_W     (PTR_W)
  ) u_blk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (blk_load),
    .data_i (blk_data_i),
    .ptr_i  (ptr_q),
    .grp_o  (grp)
  );

  rs_cand_split #(
    .MODULUS (MODULUS)
  ) u_split (
    .grp_i    (grp),
    .second_i (half_q),
    .cand_o   (cand),
    .ok_o     (cand_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      half_q  <= 1'b0;
      cnt_q   <= '0;
      sqz_q   <= 1'b0;
    end else begin
      sqz_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_WAIT;
        ptr_q   <= '0;
        half_q  <= 1'b0;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_WAIT: if (blk_load) state_q <= ST_RUN;
          ST_RUN: begin
            if (cand_step) begin
              if (coef_take) cnt_q <= cnt_q + 1'b1;
              if (last_take) begin
                state_q <= ST_DONE;
              end else if (!half_q) begin
                half_q <= 1'b1;
              end else begin
                half_q <= 1'b0;
                if (blk_end) begin
                  ptr_q   <= '0;
                  state_q <= ST_WAIT;
                  sqz_q   <= 1'b1;
                end else begin
                  ptr_q <= ptr_q + 1'b1;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign coef_o       = cand;
  assign coef_valid_o = (state_q == ST_RUN) && cand_ok;
  assign blk_ready_o  = (state_q == ST_WAIT);
  assign sqz_req_o    = sqz_q;
  assign done_o       = (state_q == ST_DONE);

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int unsigned NUM_COEFFS = 256,
  parameter int unsigned MODULUS    = 3329
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        blk_ready_o,
  input logic        sqz_req_o,
  input logic [11:0] coef_o,
  input logic        coef_valid_o,
  input logic        coef_ready_i,
  input logic        done_o,
  input logic        coef_take
);

  localparam int unsigned CW = $clog2(NUM_COEFFS + 1);
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_q <= '0;
    else if (start_i)   seen_q <= '0;
    else if (coef_take) seen_q <= seen_q + 1'b1;
  end

  assert_coef_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    coef_valid_o |-> (coef_o < 12'(MODULUS)));

  assert_coef_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid_o && !coef_ready_i && !start_i) |=> (coef_valid_o && $stable(coef_o)));

  assert_req_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sqz_req_o |-> blk_ready_o);

  assert_done_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!coef_valid_o && !blk_ready_o));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (blk_ready_o && !done_o));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    coef_take |-> (seen_q < CW'(NUM_COEFFS)));

endmodule

bind shake_rej_sampler rs_checker #(
  .NUM_COEFFS (NUM_COEFFS),
  .MODULUS    (MODULUS)
) u_rs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .blk_ready_o  (blk_ready_o),
  .sqz_req_o    (sqz_req_o),
  .coef_o       (coef_o),
  .coef_valid_o (coef_valid_o),
  .coef_ready_i (coef_ready_i),
  .done_o       (done_o),
  .coef_take    (coef_take)
);

// File: tb/test_shake_rej_sampler.sv
module test_shake_rej_sampler;

  localparam int RB = 1344;
  localparam int NB = RB / 8;
  localparam int NC = 256;
  localparam int Q  = 3329;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [RB-1:0] blk_data_i = '0;
  logic          blk_valid_i = 1'b0;
  logic          blk_ready_o;
  logic          sqz_req_o;
  logic [11:0]   coef_o;
  logic          coef_valid_o;
  logic          coef_ready_i = 1'b1;
  logic          done_o;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_coef [NC];
  int exp_blocks;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  shake_rej_sampler i_shake_rej_sampler (
    .clk, .rst_n, .start_i, .blk_data_i, .blk_valid_i, .blk_ready_o,
    .sqz_req_o, .coef_o, .coef_valid_o, .coef_ready_i, .done_o
  );

  task automatic check(input string req, input int act, input int expv, input string what);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int byte_of(input int pat, input int blk, input int idx);
    int k = idx % 3;
    case (pat)
      0: return (idx * 73 + blk * 151 + 29 + ((idx * idx) >> 3)) & 255;
      1: return (k == 0) ? 8'h00 : (k == 1) ? 8'h1D : 8'hD0;
      2: if (blk == 0 && idx < 3) return (k == 0) ? 8'hFF : (k == 1) ? 8'h2F : 8'h00;
         else return (k == 0) ? 8'h01 : (k == 1) ? 8'h20 : 8'h00;
      default: return 0;
    endcase
  endfunction

  function automatic logic [RB-1:0] make_block(input int pat, input int blk);
    logic [RB-1:0] v = '0;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = 8'(byte_of(pat, blk, i));
    return v;
  endfunction

  // Reference model: R2, R3, R4, R6 restated arithmetically.
  task automatic build_expect(input int pat);
    int got = 0;
    exp_blocks = 0;
    for (int b = 0; b < 32 && got < NC; b++) begin
      exp_blocks++;
      for (int g = 0; g < NB / 3 && got < NC; g++) begin
        int b0 = byte_of(pat, b, 3*g);
        int b1 = byte_of(pat, b, 3*g + 1);
        int b2 = byte_of(pat, b, 3*g + 2);
        int d1 = b0 + 256 * (b1 % 16);
        int d2 = (b1 / 16) + 16 * b2;
        if (d1 < Q) begin exp_coef[got] = d1; got++; end
        if (got < NC && d2 < Q) begin exp_coef[got] = d2; got++; end
      end
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    @(negedge clk);
    check("R8", blk_ready_o, 1, "ready for block after start");
    check("R8", done_o, 0, "done cleared by start");
  endtask

  task automatic run(input int pat, input bit bp, input int stop_after);
    int got = 0, fed = 0, reqs = 0, cyc = 0, bad = 0;
    bit held = 0;
    int held_v = 0;
    bit feeding = 0;
    build_expect(pat);
    pulse_start();
    while (!done_o && cyc < 6000 && (stop_after == 0 || cyc < stop_after)) begin
      if (coef_valid_o && coef_ready_i) begin
        if (stop_after == 0 && got < NC && coef_o != 12'(exp_coef[got])) begin
          bad++;
          if (bad < 4) check("R3", int'(coef_o), exp_coef[got], $sformatf("coef %0d", got));
        end
        got++;
      end
      if (held) check("R9", int'(coef_valid_o) * 4096 + int'(coef_o), 4096 + held_v, "held coef");
      held = coef_valid_o && !coef_ready_i;
      held_v = int'(coef_o);
      if (sqz_req_o) reqs++;
      if (blk_ready_o) begin
        blk_data_i = make_block(pat, fed);
        blk_valid_i = 1'b1;
        fed++;
        feeding = 1;
      end
      @(posedge clk); #1;
      if (feeding) begin blk_valid_i = 1'b0; feeding = 0; end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      coef_ready_i = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
      @(negedge clk);
      cyc++;
    end
    if (stop_after != 0) return;
    if (cyc >= 6000) check("R7", 0, 1, "run timed out");
    check("R3", bad, 0, $sformatf("mismatching coefficients pattern %0d", pat));
    check("R6", got, NC, "coefficients delivered");
    check("R5", fed, exp_blocks, "blocks consumed");
    check("R5", reqs, exp_blocks - 1, "squeeze request pulses");
    check("R7", done_o, 1, "done raised");
    begin
      int extra = 0, rq = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        extra += int'(coef_valid_o);
        rq += int'(blk_ready_o) + int'(sqz_req_o);
        if (!done_o) extra += 100;
      end
      check("R7", extra, 0, "output after done");
      check("R7", rq, 0, "leftover groups ignored, no block request");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1", int'(coef_valid_o), 0, "reset coef_valid");
    check("R1", int'(blk_ready_o), 0, "reset blk_ready");
    check("R1", int'(sqz_req_o), 0, "reset sqz_req");
    check("R1", int'(done_o), 0, "reset done");
    @(posedge clk); #1 rst_n = 1'b1;
    run(0, 0, 0);   // mixed accept/reject, R2 R3 R4
    run(0, 1, 0);   // same under back-pressure, R9
    run(1, 0, 0);   // 3328 accepted, 3329 rejected, R4; leftovers R7
    run(2, 1, 0);   // 256th is a first candidate, R6
    run(3, 0, 0);   // all zero
    run(0, 1, 150); // partial, then restart
    run(0, 0, 0);   // full run after restart, R8
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule